// File: doc/BRIEF.md
# Two-Thread Alternating Decode Front End

This block is the in-order front end shared by two hardware threads. Each thread offers one aligned 16-byte fetch chunk at a time, with a valid flag and a mask holding one bit per byte that marks where an instruction begins. On every cycle the block grants one thread. It takes up to four instruction starts from that thread's chunk, beginning at the byte position the thread reached on its previous turn. It registers them as a single bundle. Every slot in the bundle belongs to the granted thread, and the bundle carries that thread's ID.

When both threads have work, the grant switches thread on every accepted cycle. A thread that is idle, stalled or being redirected gives up its turn, so the other thread can fill every consecutive bundle. A chunk that holds more than four instructions is visited again on the thread's later turns until its last start has been emitted. At that point the chunk is acknowledged to fetch and the thread's position returns to byte 0. Downstream back-pressure freezes the bundle and all selection state.

Top module: `duo_decode_front`

## Requirements
- R1: After reset, out_valid is low and all saved positions are 0. The first grant with both threads eligible goes to thread 0 (out_tid = 0).
- R2: A bundle appears on the outputs in the cycle after its selection. Its valid slots are contiguous from slot 0 and number between 1 and 4. Slot s holds the byte index of the s-th start bit at or after the thread's saved position, in ascending order, and out_tid is the thread the bundle came from.
- R3: If both threads are eligible in a cycle where a bundle can be loaded, the grant goes to the thread that was not granted most recently.
- R4: If exactly one thread is eligible, it is granted, including on consecutive cycles.
- R5: If more than four start bits remain, the thread's saved position becomes the byte index of the fifth remaining start. No acknowledge is given, and the next pass continues from that byte.
- R6: In the cycle a thread's last remaining start is taken into a loaded bundle, in_ack for that thread is high in the same cycle and its saved position returns to 0.
- R7: A valid chunk with no start bit at or after the saved position is acknowledged in the same cycle without producing a bundle, even while out_ready is low.
- R8: A high in_flush for a thread clears its saved position. It also makes the thread ineligible and keeps its in_ack low in that cycle.
- R9: While out_valid is high and out_ready is low, the outputs stay unchanged. No grant is made, no saved position changes, and no in_ack is given for a granted chunk.
- R10: A thread is eligible when in_valid is high, in_flush is low and a start remains. If no thread is eligible when a bundle can be loaded, out_valid is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Per thread: a fetch chunk is offered |
| in_starts | input | 2x16 | Per thread: byte-start mask of the offered chunk, bit i = byte i |
| in_flush | input | 2 | Per thread: redirect; clear position, drop chunk |
| in_ack | output | 2 | Per thread: the offered chunk is fully consumed this cycle |
| out_valid | output | 1 | Bundle on the outputs is valid |
| out_ready | input | 1 | Downstream accepts the bundle this cycle |
| out_tid | output | 1 | Thread that owns every slot of the bundle |
| out_slot_vld | output | 4 | Per-slot valid, contiguous from slot 0 |
| out_slot_off | output | 4x4 | Per-slot byte index of the instruction start within the chunk |

## Verification
A wrong saved position appears on the next pass over that chunk. The slot offsets either repeat bytes already emitted or skip starts, and in_ack rises one pass early or late. A wrong record of the last grant shows up one cycle after the first cycle in which both threads are eligible, as two consecutive bundles with the same out_tid. A failure to hold state under back-pressure changes the outputs on the cycle after out_ready falls. Each of these is caught by comparing every output and in_ack on every clock with a behavioural model.

// File: rtl/duo_pkg.sv
package duo_pkg;
    localparam int unsigned DUO_THREADS = 2;
    localparam int unsigned DUO_TID_W   = 1;
endpackage

// File: rtl/duo_slot_pick.sv
// Finds up to SLOTS instruction starts at or after base_off in one chunk.
module duo_slot_pick #(
    parameter int unsigned CHUNK_BYTES = 16,
    parameter int unsigned SLOTS       = 4,
    localparam int unsigned OFF_W      = $clog2(CHUNK_BYTES),
    localparam int unsigned CNT_W      = $clog2(CHUNK_BYTES + 1)
) (
    input  logic [CHUNK_BYTES-1:0]      start_mask,
    input  logic [OFF_W-1:0]            base_off,
    output logic [SLOTS-1:0]            slot_vld,
    output logic [SLOTS-1:0][OFF_W-1:0] slot_off,
    output logic [OFF_W-1:0]            next_off,
    output logic                        last_pass,
    output logic                        empty
);
    logic [CHUNK_BYTES-1:0] rem;
    logic [CNT_W-1:0]       run;
    logic                   more;

    always_comb begin
        rem      = '0;
        slot_vld = '0;
        slot_off = '0;
        next_off = '0;
        more     = 1'b0;
        run      = '0;
        for (int i = 0; i < CHUNK_BYTES; i++) begin
            if (OFF_W'(i) >= base_off) begin
                rem[i] = start_mask[i];
            end
            if (rem[i]) begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (run == CNT_W'(s)) begin
                        slot_vld[s] = 1'b1;
                        slot_off[s] = OFF_W'(i);
                    end
                end
                if (run == CNT_W'(SLOTS)) begin
                    more     = 1'b1;
                    next_off = OFF_W'(i);
                end
                run = run + CNT_W'(1);
            end
        end
    end

    assign last_pass = !more;
    assign empty     = (rem == '0);
endmodule

// File: rtl/duo_turn_arb.sv
// Two-way turn keeper: alternate on contention, otherwise serve whoever is ready.
module duo_turn_arb (
    input  logic [1:0] elig,
    input  logic       prev,
    output logic       grant,
    output logic       any
);
    always_comb begin
        any = |elig;
        if (elig[0] && elig[1]) begin
            grant = ~prev;
        end else begin
            grant = elig[1];
        end
    end
endmodule

// File: rtl/duo_decode_front.sv
module duo_decode_front
    import duo_pkg::*;
#(
    parameter int unsigned CHUNK_BYTES = 16,
    parameter int unsigned SLOTS       = 4,
    localparam int unsigned OFF_W      = $clog2(CHUNK_BYTES),
    localparam int unsigned NT         = DUO_THREADS
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NT-1:0]                     in_valid,
    input  logic [NT-1:0][CHUNK_BYTES-1:0]    in_starts,
    input  logic [NT-1:0]                     in_flush,
    output logic [NT-1:0]                     in_ack,
    output logic                              out_valid,
    input  logic                              out_ready,
    output logic [DUO_TID_W-1:0]              out_tid,
    output logic [SLOTS-1:0]                  out_slot_vld,
    output logic [SLOTS-1:0][OFF_W-1:0]       out_slot_off
);
    typedef struct packed {
        logic                        vld;
        logic [DUO_TID_W-1:0]        tid;
        logic [SLOTS-1:0]            svld;
        logic [SLOTS-1:0][OFF_W-1:0] soff;
    } bundle_t;

    typedef struct packed {
        bundle_t                     bnd;
        logic [DUO_TID_W-1:0]        prev;
        logic [NT-1:0][OFF_W-1:0]    off;
    } state_t;

    state_t st_q, st_d;

    logic [NT-1:0][SLOTS-1:0]            pk_vld;
    logic [NT-1:0][SLOTS-1:0][OFF_W-1:0] pk_off;
    logic [NT-1:0][OFF_W-1:0]            pk_next;
    logic [NT-1:0]                       pk_last;
    logic [NT-1:0]                       pk_empty;
    logic [NT-1:0]                       elig;
    logic                                grant;
    logic                                any;
    logic                                adv;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        duo_slot_pick #(
            .CHUNK_BYTES(CHUNK_BYTES),
            .SLOTS      (SLOTS)
        ) u_pick (
            .start_mask(in_starts[t]),
            .base_off  (st_q.off[t]),
            .slot_vld  (pk_vld[t]),
            .slot_off  (pk_off[t]),
            .next_off  (pk_next[t]),
            .last_pass (pk_last[t]),
            .empty     (pk_empty[t])
        );
        assign elig[t] = in_valid[t] && !in_flush[t] && !pk_empty[t];
    end

    duo_turn_arb u_arb (
        .elig (elig),
        .prev (st_q.prev),
        .grant(grant),
        .any  (any)
    );

    always_comb begin
        logic take;
        st_d   = st_q;
        in_ack = '0;
        adv    = !st_q.bnd.vld || out_ready;
        if (adv) begin
            st_d.bnd.vld = any;
            if (any) begin
                st_d.bnd.tid  = grant;
                st_d.bnd.svld = pk_vld[grant];
                st_d.bnd.soff = pk_off[grant];
                st_d.prev     = grant;
            end
        end
        for (int t = 0; t < NT; t++) begin
            take = adv && any && (grant == DUO_TID_W'(t));
            if (take) begin
                st_d.off[t] = pk_last[t] ? '0 : pk_next[t];
            end
            if (in_flush[t]) begin
                st_d.off[t] = '0;
            end
            in_ack[t] = in_valid[t] && !in_flush[t] &&
                        (pk_empty[t] || (take && pk_last[t]));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.bnd.vld;
    assign out_tid      = st_q.bnd.tid;
    assign out_slot_vld = st_q.bnd.svld;
    assign out_slot_off = st_q.bnd.soff;
endmodule

// File: rtl/duo_decode_front_chk.sv
module duo_decode_front_chk
    import duo_pkg::*;
#(
    parameter int unsigned CHUNK_BYTES = 16,
    parameter int unsigned SLOTS       = 4,
    localparam int unsigned OFF_W      = $clog2(CHUNK_BYTES),
    localparam int unsigned NT         = DUO_THREADS
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NT-1:0]                  in_valid,
    input logic [NT-1:0]                  in_flush,
    input logic [NT-1:0]                  in_ack,
    input logic                           out_valid,
    input logic                           out_ready,
    input logic [DUO_TID_W-1:0]           out_tid,
    input logic [SLOTS-1:0]               out_slot_vld,
    input logic [SLOTS-1:0][OFF_W-1:0]    out_slot_off
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid); // R1

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_tid) &&
        $stable(out_slot_vld) && $stable(out_slot_off)); // R9

    AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_slot_vld != '0) &&
        ((out_slot_vld & (out_slot_vld + SLOTS'(1))) == '0)); // R2

    for (genvar s = 1; s < SLOTS; s++) begin : g_asc
        AST_OFF_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && out_slot_vld[s] |-> out_slot_off[s] > out_slot_off[s-1]); // R2
    end

    for (genvar t = 0; t < NT; t++) begin : g_ack
        AST_ACK_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
            in_ack[t] |-> in_valid[t] && !in_flush[t]); // R8
    end

    AST_IDLE_NO_BUNDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(|in_valid)); // R10
endmodule

bind duo_decode_front duo_decode_front_chk #(
    .CHUNK_BYTES(CHUNK_BYTES),
    .SLOTS      (SLOTS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_flush    (in_flush),
    .in_ack      (in_ack),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_tid     (out_tid),
    .out_slot_vld(out_slot_vld),
    .out_slot_off(out_slot_off)
);

// File: tb/sim_duo_decode_front.sv
module sim_duo_decode_front;
    localparam int PERIOD = 10;
    localparam int CB     = 16;
    localparam int SL     = 4;
    localparam int OW     = 4;
    localparam int WD     = 200000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [1:0]         in_valid = '0;
    logic [1:0][CB-1:0] in_starts = '0;
    logic [1:0]         in_flush = '0;
    logic [1:0]         in_ack;
    logic               out_valid;
    logic               out_ready = 1'b0;
    logic [0:0]         out_tid;
    logic [SL-1:0]      out_slot_vld;
    logic [SL-1:0][OW-1:0] out_slot_off;

    duo_decode_front u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_starts(in_starts),
        .in_flush(in_flush), .in_ack(in_ack), .out_valid(out_valid),
        .out_ready(out_ready), .out_tid(out_tid), .out_slot_vld(out_slot_vld),
        .out_slot_off(out_slot_off)
    );

    always #(PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [CB-1:0] q0[$];
    logic [CB-1:0] q1[$];
    bit stall0 = 0, stall1 = 0, rdy = 1, fl0 = 0, fl1 = 0;

    bit m_vld = 0;
    int m_tid = 0;
    int m_svld = 0;
    int m_soff[SL];
    int m_off[2];
    int m_prev = 1;
    int unsigned lfsr = 32'h1234_5678;

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        lfsr ^= lfsr << 13;
        lfsr ^= lfsr >> 17;
        lfsr ^= lfsr << 5;
        return lfsr;
    endfunction

    task automatic step();
        bit vin[2];
        bit fl[2];
        logic [CB-1:0] mk[2];
        int pos[2][CB];
        int cnt[2];
        bit el[2];
        bit adv, any, take, ea;
        int sel;
        @(negedge clk);
        chk("R10", "out_valid", int'(out_valid), int'(m_vld));
        if (m_vld) begin
            chk("R3 R4", "out_tid", int'(out_tid), m_tid);
            chk("R2 R9", "slot_vld", int'(out_slot_vld), m_svld);
            for (int s = 0; s < SL; s++)
                if (m_svld[s]) chk("R2 R5", "slot_off", int'(out_slot_off[s]), m_soff[s]);
        end
        vin[0] = (q0.size() > 0) && !stall0;
        vin[1] = (q1.size() > 0) && !stall1;
        mk[0] = (q0.size() > 0) ? q0[0] : '0;
        mk[1] = (q1.size() > 0) ? q1[0] : '0;
        fl[0] = fl0;
        fl[1] = fl1;
        in_valid[0] = vin[0];
        in_valid[1] = vin[1];
        in_starts[0] = mk[0];
        in_starts[1] = mk[1];
        in_flush = {fl1, fl0};
        out_ready = rdy;
        #1;
        adv = !m_vld || rdy;
        for (int t = 0; t < 2; t++) begin
            cnt[t] = 0;
            for (int b = m_off[t]; b < CB; b++)
                if (mk[t][b]) begin pos[t][cnt[t]] = b; cnt[t]++; end
            el[t] = vin[t] && !fl[t] && cnt[t] > 0;
        end
        any = el[0] || el[1];
        if (el[0] && el[1]) sel = 1 - m_prev;
        else sel = el[1] ? 1 : 0;
        for (int t = 0; t < 2; t++) begin
            take = adv && any && sel == t;
            ea = vin[t] && !fl[t] && (cnt[t] == 0 || (take && cnt[t] <= SL));
            chk(fl[t] ? "R8" : (cnt[t] == 0 ? "R7" : (adv ? "R6" : "R9")),
                "in_ack", int'(in_ack[t]), int'(ea));
            if (take) m_off[t] = (cnt[t] > SL) ? pos[t][SL] : 0;
            if (fl[t]) m_off[t] = 0;
            if (ea || fl[t]) begin
                if (t == 0 && q0.size() > 0) void'(q0.pop_front());
                if (t == 1 && q1.size() > 0) void'(q1.pop_front());
            end
        end
        if (adv) begin
            m_vld = any;
            if (any) begin
                m_tid = sel;
                m_prev = sel;
                m_svld = 0;
                for (int s = 0; s < SL; s++)
                    if (s < cnt[sel]) begin m_svld |= (1 << s); m_soff[s] = pos[sel][s]; end
            end
        end
    endtask

    initial begin
        for (int s = 0; s < SL; s++) m_soff[s] = 0;
        m_off[0] = 0;
        m_off[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "in_ack idle", int'(in_ack), 0);

        // directed mix: long chunk, empty chunk, alternation, single thread
        q0 = '{16'hFFFF, 16'h0001, 16'h0000, 16'h8421};
        q1 = '{16'h0003, 16'hAAAA, 16'h1000};
        rdy = 1;
        repeat (20) step();

        // back-pressure with both threads busy
        q0 = '{16'hFFFF};
        q1 = '{16'hF0F0};
        for (int i = 0; i < 14; i++) begin rdy = (i % 3 != 1); step(); end
        rdy = 1;
        repeat (8) step();

        // flush in the middle of a long chunk
        q0 = '{16'hFFFF, 16'h0011};
        q1 = '{16'hFFFF};
        repeat (2) step();
        fl0 = 1; step(); fl0 = 0;
        repeat (10) step();

        // idle: nothing offered
        repeat (3) step();

        // pseudo-random traffic
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = rnd();
            if (q0.size() < 2) q0.push_back((r[3:0] == 0) ? 16'h0 : 16'(rnd() & rnd()));
            if (q1.size() < 2) q1.push_back((r[7:4] == 0) ? 16'h0 : 16'(rnd()));
            stall0 = (r[10:8] == 0);
            stall1 = (r[13:11] == 0);
            rdy    = (r[15:14] != 0);
            fl0    = (r[21:16] == 0);
            fl1    = (r[27:22] == 0);
            step();
        end
        stall0 = 0; stall1 = 0; fl0 = 0; fl1 = 0; rdy = 1;
        repeat (30) step();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog actual=%0d expected<%0d cycles", WD, WD);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule